// File: doc/BRIEF.md
# Quad-Lane Serial Pseudo-Static RAM Controller

This block sits on the host side of a self-refreshing serial RAM that is reached over chip select, a serial clock and four shared data lanes. A request carries a direction, a 32-bit linear byte address and a burst length of one to sixteen bytes. For each request the controller selects the device and sends an opcode byte and then the address, most significant nibble first. It then either streams write bytes from the host onto the lanes or releases the lanes for a fixed number of turnaround clocks and collects read bytes. The device is deselected once the last byte is done.

Every lane changes only while the serial clock is low and is sampled on its rising edge. The serial clock runs at the system clock divided by `2*CLK_DIV`, so `CLK_DIV` can be set to keep it under the device's 54 MHz limit. Because opcode, address and data share the same four lanes, one transfer must finish and the device must be deselected before the next one starts.

Write bytes come in on a valid/ready stream. The controller raises `wr_ready` only in the cycle it puts a byte on the lanes. If `wr_valid` is low at that point, the serial clock is paused high until a byte arrives. Read bytes go out on a valid/ready stream. A byte stays on `rd_data` with `rd_valid` high until `rd_ready` takes it. While an untaken byte is held, the serial clock is paused high before the next byte starts. Requests use a valid/ready handshake and are taken only while the block is idle.

Top module: `qspi_psram_ctrl`

## Requirements
- R1: While reset is held and directly after it, `cs_n` is 1, `sck` is 0, `dq_oe` is 0, `req_ready` is 1, and `busy`, `done` and `rd_valid` are 0.
- R2: The first two serial clocks of a transfer carry opcode 0x38 for a write or 0xEB for a read, high nibble first. The nibble sits on `dq_o[3:0]` with bit 3 as the nibble's most significant bit, and `dq_oe` is 1.
- R3: The next eight serial clocks carry the 32-bit request address, most significant nibble first.
- R4: A write then sends `req_len+1` bytes taken in order from the write stream, high nibble first. A byte is taken only when `wr_valid` and `wr_ready` are both 1. If no byte is offered when one is due, the clock pauses with `sck` high.
- R5: A read sets `dq_oe` to 0 after the address. It lets `DUMMY_CYCLES` serial clocks pass, then samples `2*(req_len+1)` nibbles on rising edges and returns them in order as bytes (first nibble is the high half) on `rd_data` with `rd_valid`.
- R6: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays 1 and `rd_data` stays unchanged. The serial clock stops before a further byte is sampled.
- R7: With no pause, each serial-clock half period lasts `CLK_DIV` system cycles. `cs_n` stays low for exactly `2*CLK_DIV` system cycles per serial clock of the transfer.
- R8: `cs_n` rises on the falling serial edge that ends the final byte. `done` is 1 for exactly that one cycle. `busy` is 1 from the cycle after acceptance until `cs_n` rises.
- R9: Between transfers `cs_n` stays high for at least `2*CLK_DIV` system cycles. `sck` is 0 and `dq_oe` is 0 while `cs_n` is 1, and `req_ready` is 0 while `cs_n` is 0.
- R10: A request is taken only on a cycle with `req_valid` and `req_ready` both 1, and its fields are captured then. `req_valid` raised while busy and dropped before the block returns to idle starts nothing, and changing the fields after acceptance does not alter the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Linear byte address |
| req_len | input | 4 | Burst length minus one |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken this cycle |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte held on `rd_data` |
| rd_ready | input | 1 | Host takes the read byte |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle pulse when the transfer ends |
| busy | output | 1 | Device selected for a transfer |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| dq_o | output | 4 | Lane values driven to the device |
| dq_oe | output | 1 | Lane output enable |
| dq_i | input | 4 | Lane values sampled from the device |

## Verification
After the accepting edge, the first serial rising edge comes `CLK_DIV` system cycles later. Each later edge follows `CLK_DIV` cycles after the previous one unless a stream pauses the clock. A read byte shows up on `rd_valid` at the rising edge of its second nibble, and `cs_n` and `done` change together at the last falling edge. The bench samples every output half a system clock after the active edge. A device model counts serial edges from the fall of `cs_n` and checks each nibble in the serial period it belongs to. The exact `cs_n` low time is compared only on transfers where the bench never withholds a write byte or a read acceptance, since any pause lengthens the transfer.

// File: rtl/qspi_psram_pkg.sv
package qspi_psram_pkg;
  localparam logic [7:0] OP_READ  = 8'hEB;
  localparam logic [7:0] OP_WRITE = 8'h38;
  localparam int unsigned NIB_W   = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } xfer_state_t;
endpackage

// File: rtl/qspi_tick_gen.sv
module qspi_tick_gen #(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic stall,
  output logic tick
);
  localparam int unsigned CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;
  logic at_last;

  assign at_last = (cnt == LAST);
  assign tick    = run && at_last && !stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (at_last) begin
      if (!stall) cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/qspi_tx_shift.sv
module qspi_tx_shift #(
  parameter int unsigned SH_W = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_hdr,
  input  logic [SH_W-1:0] hdr,
  input  logic            load_byte,
  input  logic [7:0]      byte_in,
  input  logic            shift,
  output logic [3:0]      nib_out
);
  logic [SH_W-1:0] sh;

  assign nib_out = sh[SH_W-1 -: 4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
    end else if (load_hdr) begin
      sh <= hdr;
    end else if (load_byte) begin
      sh[SH_W-1 -: 8] <= byte_in;
    end else if (shift) begin
      sh <= {sh[SH_W-5:0], 4'h0};
    end
  end
endmodule

// File: rtl/qspi_rx_assembler.sv
module qspi_rx_assembler #(
  parameter int unsigned NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap,
  input  logic               cap_hi,
  input  logic [NIB_W-1:0]   nib_in,
  input  logic               take,
  output logic               byte_valid,
  output logic [2*NIB_W-1:0] byte_out
);
  logic [NIB_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q       <= '0;
      byte_valid <= 1'b0;
      byte_out   <= '0;
    end else begin
      if (take) byte_valid <= 1'b0;
      if (cap) begin
        if (cap_hi) begin
          hi_q <= nib_in;
        end else begin
          byte_out   <= {hi_q, nib_in};
          byte_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/qspi_psram_ctrl.sv
module qspi_psram_ctrl
  import qspi_psram_pkg::*;
#(
  parameter int unsigned CLK_DIV      = 2,
  parameter int unsigned DUMMY_CYCLES = 6,
  parameter int unsigned MAX_BURST    = 16,
  parameter int unsigned ADDR_W       = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [$clog2(MAX_BURST)-1:0] req_len,
  input  logic                         wr_valid,
  output logic                         wr_ready,
  input  logic [7:0]                   wr_data,
  output logic                         rd_valid,
  input  logic                         rd_ready,
  output logic [7:0]                   rd_data,
  output logic                         done,
  output logic                         busy,
  output logic                         cs_n,
  output logic                         sck,
  output logic [3:0]                   dq_o,
  output logic                         dq_oe,
  input  logic [3:0]                   dq_i
);
  localparam int unsigned LEN_W     = $clog2(MAX_BURST);
  localparam int unsigned HDR_W     = 8 + ADDR_W;
  localparam int unsigned HDR_PER   = HDR_W / NIB_W;
  localparam int unsigned MAX_PER   = HDR_PER + DUMMY_CYCLES + 2 * MAX_BURST;
  localparam int unsigned PER_W     = $clog2(MAX_PER + 1);
  localparam logic [PER_W-1:0] P_HDR = PER_W'(HDR_PER);
  localparam logic [PER_W-1:0] P_RDS = PER_W'(HDR_PER + DUMMY_CYCLES);

  xfer_state_t      state;
  logic             is_wr;
  logic [PER_W-1:0] per, last_per;
  logic             cs_n_q, sck_q, oe_q, done_q, gap_half;

  logic             tick, stall, accept;
  logic             rise_evt, fall_evt, ending, byte_start;
  logic             need_w, need_r, cap, cap_hi;
  logic [PER_W-1:0] next_per, data_start, rel_next, rel_cur;

  assign accept     = req_valid && (state == ST_IDLE);
  assign next_per   = per + 1'b1;
  assign data_start = is_wr ? P_HDR : P_RDS;
  assign rel_next   = next_per - data_start;
  assign rel_cur    = per - data_start;
  assign ending     = (next_per == last_per);
  assign byte_start = (next_per >= data_start) && !rel_next[0] && !ending;
  assign need_w     = is_wr && byte_start;
  assign need_r     = !is_wr && byte_start;

  assign stall = (state == ST_XFER) && sck_q &&
                 ((need_w && !wr_valid) || (need_r && rd_valid && !rd_ready));

  assign rise_evt = tick && (state == ST_XFER) && !sck_q;
  assign fall_evt = tick && (state == ST_XFER) && sck_q;
  assign cap      = rise_evt && !is_wr && (per >= data_start);
  assign cap_hi   = !rel_cur[0];
  assign wr_ready = fall_evt && need_w;

  qspi_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state != ST_IDLE),
    .stall (stall),
    .tick  (tick)
  );

  qspi_tx_shift #(.SH_W(HDR_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_hdr  (accept),
    .hdr       ({(req_write ? OP_WRITE : OP_READ), req_addr}),
    .load_byte (wr_ready),
    .byte_in   (wr_data),
    .shift     (fall_evt && !ending && !need_w),
    .nib_out   (dq_o)
  );

  qspi_rx_assembler #(.NIB_W(NIB_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap        (cap),
    .cap_hi     (cap_hi),
    .nib_in     (dq_i),
    .take       (rd_ready),
    .byte_valid (rd_valid),
    .byte_out   (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      is_wr    <= 1'b0;
      per      <= '0;
      last_per <= '0;
      cs_n_q   <= 1'b1;
      sck_q    <= 1'b0;
      oe_q     <= 1'b0;
      done_q   <= 1'b0;
      gap_half <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_XFER;
            is_wr    <= req_write;
            per      <= '0;
            last_per <= P_HDR + (req_write ? PER_W'(0) : PER_W'(DUMMY_CYCLES))
                        + PER_W'({req_len, 1'b0}) + PER_W'(2);
            cs_n_q   <= 1'b0;
            oe_q     <= 1'b1;
          end
        end
        ST_XFER: begin
          if (rise_evt) sck_q <= 1'b1;
          if (fall_evt) begin
            sck_q <= 1'b0;
            per   <= next_per;
            if (ending) begin
              state    <= ST_GAP;
              cs_n_q   <= 1'b1;
              oe_q     <= 1'b0;
              done_q   <= 1'b1;
              gap_half <= 1'b0;
            end else if (!is_wr && next_per == P_HDR) begin
              oe_q <= 1'b0;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            gap_half <= 1'b1;
            if (gap_half) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign cs_n      = cs_n_q;
  assign sck       = sck_q;
  assign dq_oe     = oe_q;
  assign done      = done_q;
  assign busy      = !cs_n_q;
endmodule

// File: rtl/qspi_psram_ctrl_chk.sv
module qspi_psram_ctrl_chk #(
  parameter int unsigned CLK_DIV = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic       dq_oe,
  input logic       done,
  input logic       req_ready,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data
);
  localparam int unsigned CW = $clog2(2 * CLK_DIV + 2) + 1;
  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] hi_cnt, run_len;
  logic          prev_sck, toggled;

  assign toggled = (sck != prev_sck);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= SAT;
      run_len  <= SAT;
      prev_sck <= 1'b0;
    end else begin
      prev_sck <= sck;
      if (!cs_n)            hi_cnt <= '0;
      else if (hi_cnt != SAT) hi_cnt <= hi_cnt + 1'b1;
      if (toggled)           run_len <= CW'(1);
      else if (run_len != SAT) run_len <= run_len + 1'b1;
    end
  end

  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt >= CW'(2 * CLK_DIV)));  // R9
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);  // R9
  AST_LANES_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !dq_oe);  // R9
  AST_NO_REQ_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);  // R9
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));  // R8
  AST_SCK_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    toggled |-> (run_len >= CW'(CLK_DIV)));  // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));  // R6
  AST_WR_TAKE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!cs_n && sck));  // R4
endmodule

bind qspi_psram_ctrl qspi_psram_ctrl_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sck       (sck),
  .dq_oe     (dq_oe),
  .done      (done),
  .req_ready (req_ready),
  .wr_ready  (wr_ready),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data)
);

// File: tb/qspi_psram_ctrl_bench.sv
module qspi_psram_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int DUMMY      = 6;
  localparam int HDR        = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0] req_len = '0;
  logic       wr_valid = 1'b0, rd_ready = 1'b1;
  logic [7:0] wr_data = '0;
  logic [3:0] dq_i = '0;
  logic       req_ready, wr_ready, rd_valid, done, busy, cs_n, sck, dq_oe;
  logic [7:0] rd_data;
  logic [3:0] dq_o;

  qspi_psram_ctrl #(.CLK_DIV(DIV), .DUMMY_CYCLES(DUMMY)) u_qspi_psram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .busy(busy), .cs_n(cs_n), .sck(sck),
    .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int vec = 0, errs = 0;
  logic [7:0] dev_mem [256];
  logic [7:0] ref_mem [256];
  logic [7:0] exp_bytes [16];
  logic [7:0] dev_w [16];
  bit exp_wr = 1'b0, nostall = 1'b1, block_rd = 1'b0, have_rise = 1'b0;
  logic [31:0] exp_addr = '0, dev_addr = '0;
  logic [7:0] dev_cmd = '0, rd_cap = '0, prev_rd_data = '0;
  int exp_n = 0, w_idx = 0, r_idx = 0, xfer_count = 0, cyc = 0;
  int r_cnt = 0, f_cnt = 0, fall_cyc = 0, rise_cyc = 0, sck_toggles = 0;
  bit wfire = 1'b0, rfire = 1'b0, prev_hold = 1'b0, prev_cs = 1'b1, prev_sck = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    vec++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] seed_byte(input int i);
    return 8'(i * 7 + 3);
  endfunction

  // Device model and stream drivers, half a clock after each active edge
  initial begin
    forever begin
      @(negedge clk); #1;
      cyc++;
      if (wfire) w_idx++;
      if (rfire) begin
        chk(r_idx < exp_n && rd_cap == exp_bytes[r_idx & 15], "R5 read byte",
            rd_cap, exp_bytes[r_idx & 15]);
        r_idx++;
      end
      if (prev_hold)
        chk(rd_valid && rd_data == prev_rd_data, "R6 held byte", rd_data, prev_rd_data);
      if (sck != prev_sck) sck_toggles++;
      if (done || (!prev_cs && cs_n))
        chk(done == (!prev_cs && cs_n), "R8 done at release", done, !prev_cs && cs_n);
      if (prev_cs && !cs_n) begin
        chk(busy == 1'b1, "R8 busy while selected", busy, 1);
        if (have_rise) chk(cyc - rise_cyc >= 2 * DIV, "R9 deselect gap", cyc - rise_cyc, 2 * DIV);
        r_cnt = 0; f_cnt = 0; dev_cmd = '0; dev_addr = '0; fall_cyc = cyc;
      end
      if (!prev_cs && !prev_sck && sck) begin
        if (r_cnt == 0) chk(dq_oe == 1'b1, "R2 lanes driven", dq_oe, 1);
        if (r_cnt < 2) dev_cmd = {dev_cmd[3:0], dq_o};
        else if (r_cnt < HDR) dev_addr = {dev_addr[27:0], dq_o};
        else if (dev_cmd == 8'h38) begin
          if ((r_cnt - HDR) / 2 < 16) begin
            if ((r_cnt - HDR) % 2 == 0) dev_w[(r_cnt - HDR) / 2][7:4] = dq_o;
            else dev_w[(r_cnt - HDR) / 2][3:0] = dq_o;
          end
        end else if (r_cnt == HDR || r_cnt == HDR + DUMMY)
          chk(dq_oe == 1'b0, "R5 lanes released", dq_oe, 0);
        r_cnt++;
      end
      if (!prev_cs && prev_sck && !sck) begin
        f_cnt++;
        if (dev_cmd == 8'hEB && f_cnt >= HDR + DUMMY) begin
          automatic int j = f_cnt - HDR - DUMMY;
          automatic logic [7:0] b = dev_mem[8'(dev_addr + 32'(j / 2))];
          dq_i = (j % 2 == 0) ? b[7:4] : b[3:0];
        end
      end
      if (!prev_cs && cs_n) begin
        rise_cyc = cyc; have_rise = 1'b1;
        chk(busy == 1'b0, "R8 busy cleared", busy, 0);
        chk(dev_cmd == (exp_wr ? 8'h38 : 8'hEB), "R2 opcode", dev_cmd, exp_wr ? 8'h38 : 8'hEB);
        chk(dev_addr == exp_addr, "R3 address", dev_addr, exp_addr);
        chk(r_cnt == HDR + (exp_wr ? 0 : DUMMY) + 2 * exp_n, "R5 serial clock count",
            r_cnt, HDR + (exp_wr ? 0 : DUMMY) + 2 * exp_n);
        if (exp_wr)
          for (int i = 0; i < exp_n; i++) begin
            chk(dev_w[i] == exp_bytes[i], "R4 write byte", dev_w[i], exp_bytes[i]);
            dev_mem[8'(exp_addr + 32'(i))] = dev_w[i];
          end
        if (nostall)
          chk(cyc - fall_cyc == 2 * DIV * r_cnt, "R7 select time", cyc - fall_cyc, 2 * DIV * r_cnt);
        xfer_count++;
      end
      wr_valid = exp_wr && w_idx < exp_n && (nostall || ($urandom % 3 != 0));
      wr_data  = exp_bytes[w_idx & 15];
      rd_ready = !block_rd && (nostall || ($urandom % 4 != 0));
      #1;
      wfire = wr_valid && wr_ready;
      rfire = rd_valid && rd_ready;
      rd_cap = rd_data;
      prev_hold = rd_valid && !rd_ready;
      prev_rd_data = rd_data;
      prev_cs = cs_n;
      prev_sck = sck;
    end
  end

  task automatic xfer(input bit w, input logic [31:0] a, input int lm1, input bit ns);
    automatic int target = xfer_count + 1;
    @(negedge clk); #2;
    exp_wr = w; exp_addr = a; exp_n = lm1 + 1; nostall = ns;
    for (int i = 0; i < exp_n; i++) begin
      if (w) begin
        exp_bytes[i] = 8'($urandom);
        ref_mem[8'(a + 32'(i))] = exp_bytes[i];
      end else exp_bytes[i] = ref_mem[8'(a + 32'(i))];
    end
    w_idx = 0; r_idx = 0;
    req_write = w; req_addr = a; req_len = 4'(lm1); req_valid = 1'b1;
    while (!req_ready) begin @(negedge clk); #2; end
    @(negedge clk); #2;
    req_valid = 1'b0;
    wait (xfer_count == target);
    while (r_idx < exp_n && !w) @(negedge clk);
    #3;
    if (w) chk(w_idx == exp_n, "R4 bytes taken", w_idx, exp_n);
    else   chk(r_idx == exp_n, "R5 bytes returned", r_idx, exp_n);
  endtask

  initial begin
    void'($urandom(32'd20240518));
    for (int i = 0; i < 256; i++) begin
      dev_mem[i] = seed_byte(i);
      ref_mem[i] = seed_byte(i);
    end
    repeat (4) @(negedge clk);
    #3;
    chk(cs_n && !sck && !dq_oe && req_ready && !busy && !rd_valid && !done,
        "R1 reset state", {cs_n, sck, dq_oe, req_ready, busy, rd_valid, done}, 7'b1001000);
    rst_n = 1'b1;
    @(negedge clk); #3;
    chk(cs_n && !sck && !dq_oe && req_ready && !busy && !rd_valid && !done,
        "R1 after reset", {cs_n, sck, dq_oe, req_ready, busy, rd_valid, done}, 7'b1001000);

    xfer(1'b1, 32'h1234_56F8, 15, 1'b1);   // full burst wrapping the low address byte
    xfer(1'b0, 32'h1234_56F8, 15, 1'b1);
    xfer(1'b1, 32'hFFFF_FFFF, 0, 1'b1);    // single byte at the top address
    xfer(1'b0, 32'hFFFF_FFFF, 0, 1'b1);
    xfer(1'b1, 32'hA5A5_0010, 7, 1'b0);    // write with withheld bytes
    xfer(1'b0, 32'hA5A5_0010, 7, 1'b0);    // read with random back-pressure

    // R6: read bytes refused for a long stretch
    block_rd = 1'b1;
    fork
      xfer(1'b0, 32'h0000_0040, 3, 1'b0);
      begin
        wait (rd_valid);
        repeat (20) @(negedge clk);
        #3;
        begin
          automatic int t0 = sck_toggles;
          automatic logic [7:0] d0 = rd_data;
          repeat (20) @(negedge clk);
          #3;
          chk(sck_toggles == t0, "R6 clock paused", sck_toggles, t0);
          chk(rd_valid && rd_data == d0, "R6 byte kept", rd_data, d0);
        end
        block_rd = 1'b0;
      end
    join

    // R10: request raised while busy and fields changed after acceptance
    fork
      xfer(1'b1, 32'h0BAD_F00D, 5, 1'b1);
      begin
        wait (!cs_n);
        @(negedge clk); #3;
        req_valid = 1'b1; req_addr = 32'hDEAD_BEEF; req_write = 1'b0;
        repeat (10) @(negedge clk);
        #3;
        req_valid = 1'b0;
      end
    join
    begin
      automatic int n0 = xfer_count;
      repeat (30) @(negedge clk);
      #3;
      chk(xfer_count == n0 && cs_n, "R10 no stray transfer", xfer_count, n0);
    end

    for (int k = 0; k < 80; k++)
      xfer(1'($urandom), $urandom, int'($urandom % 16), 1'($urandom));
    for (int k = 0; k < 8; k++)
      xfer(1'b0, 32'h1234_5600 + 32'(k * 32), 15, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end
endmodule